// File: doc/BRIEF.md
# Isochronous Split-Transaction State Tracker

This block follows the split state of a periodic full-speed isochronous descriptor that a high-speed host sends through a transaction-translating hub. It holds two descriptor contexts: the one scheduled in the current frame and the one left over from the frame before. When a micro-frame is visited, the block decides whether the earlier descriptor still owes complete-splits and must be serviced through its back-link, then decides whether the current descriptor issues a start-split, a complete-split, or nothing. For each split it wants, it raises a request to an external transaction engine and waits for the handshake or data PID that comes back.

Descriptor fetch is modelled as a load strobe. On a load, the current context moves into the previous slot and the new descriptor takes its place, so split state carries across frame boundaries. Write-back is visible as the state, Active and error outputs of both contexts. The frame-list walk and the bus engine sit outside the block.

Top module: `iso_split_tracker`

## Requirements
- R1: After reset both contexts are inactive, in the start-split state (state code 0), with the error flag clear; `tx_req` and `busy` are low.
- R2: A `desc_load` accepted while idle copies the current context unchanged into the previous slot. It then sets the current context active, error clear, with the given masks, in the complete-split state (code 1) when `ld_carry` is 1 and in the start-split state (code 0) otherwise. A tick in the same cycle is ignored.
- R3: In the start-split state a start-split (kind 1) is requested only in a micro-frame whose S-mask bit is set, and C-mask bits have no effect. Any response to a start-split moves the state to complete-split.
- R4: In the complete-split state a complete-split (kind 2) is requested in every visited micro-frame whose C-mask bit is set.
- R5: An MDATA response (code 2) to a complete-split leaves Active set and the state at complete-split, including on the last scheduled complete-split.
- R6: A DATA0 response (code 3) to a complete-split clears Active and returns the state to start-split, so any complete-splits still scheduled later in that frame are not requested.
- R7: A response of none (code 0) or of any code other than 2 or 3 to a complete-split leaves the context unchanged, unless no higher C-mask bit is set. In that case it clears Active, sets the error flag and returns the state to start-split.
- R8: The previous context is serviced (tx_ctx 1, always kind 2) only when `ld_back_ok` was 1 at the last load, bit 0 of the current S-mask is 0, and the previous context is active, in complete-split state, and has the C-mask bit of this micro-frame set. That service comes before the current context's action in the same micro-frame.
- R9: When the previous context needs no service, no transaction is made for it and its state, Active and error outputs are unchanged.
- R10: `tx_req` stays high with stable `tx_kind` and `tx_ctx` until `tx_done`; `busy` is high from the cycle after an accepted tick until the visit is finished.
- R11: `frame_wrap` pulses for one cycle, one clock after an accepted tick of index 0 whose preceding accepted tick had index 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uf_tick | input | 1 | Visit strobe for one micro-frame, accepted while idle |
| uf_idx | input | 3 | Micro-frame index of the visit |
| desc_load | input | 1 | Load a new current descriptor, accepted while idle |
| ld_smask | input | 8 | Start-split micro-frame mask of the new descriptor |
| ld_cmask | input | 8 | Complete-split micro-frame mask of the new descriptor |
| ld_carry | input | 1 | New descriptor starts in the complete-split state |
| ld_back_ok | input | 1 | Back-link to the previous descriptor is valid |
| tx_req | output | 1 | Split transaction requested |
| tx_kind | output | 2 | 1 start-split, 2 complete-split |
| tx_ctx | output | 1 | 0 current context, 1 previous context |
| tx_done | input | 1 | Transaction finished, response valid |
| tx_resp | input | 3 | 0 none, 1 ACK, 2 MDATA, 3 DATA0, 4..7 other |
| busy | output | 1 | Visit in progress |
| frame_wrap | output | 1 | Frame boundary pulse |
| cur_state | output | 1 | Current context split state |
| cur_active | output | 1 | Current context Active |
| cur_err | output | 1 | Current context error |
| prev_state | output | 1 | Previous context split state |
| prev_active | output | 1 | Previous context Active |
| prev_err | output | 1 | Previous context error |

## Verification
The hardest case to reach from the ports is servicing the previous descriptor through the back-link. It needs a descriptor that ends its frame still active in complete-split state: the bench answers its last scheduled complete-split with MDATA, then loads a successor whose S-mask bit 0 is clear. Further frames leave a descriptor pending in the same way and then block its service, once with S-mask bit 0 set and once with the back-link invalid. The previous-context outputs are read to confirm it was left untouched. Early completion and the error exit on the last complete-split are reached by choosing DATA0, none or other responses against C-masks with several bits set.

// File: rtl/sst_pkg.sv
package sst_pkg;
    localparam int UF_N    = 8;
    localparam int UF_W    = $clog2(UF_N);
    localparam int NCTX    = 2;
    localparam int RSP_W   = 3;
    localparam logic SEL_CUR  = 1'b0;
    localparam logic SEL_PREV = 1'b1;

    typedef logic [UF_N-1:0] mask_t;
    typedef logic [UF_W-1:0] uf_t;

    typedef enum logic { ST_SS = 1'b0, ST_CS = 1'b1 } st_e;
    typedef enum logic [1:0] { ACT_NONE = 2'd0, ACT_SS = 2'd1, ACT_CS = 2'd2 } act_e;
    typedef enum logic [RSP_W-1:0] {
        RSP_NONE = 3'd0, RSP_ACK = 3'd1, RSP_MDATA = 3'd2,
        RSP_DATA0 = 3'd3, RSP_OTHER = 3'd4
    } rsp_e;
    typedef enum logic [1:0] { SQ_IDLE, SQ_PREV, SQ_CUR, SQ_WAIT } sq_e;

    typedef struct packed {
        st_e   st;
        logic  active;
        logic  err;
        mask_t smask;
        mask_t cmask;
    } ctx_t;

    function automatic rsp_e decode_rsp(logic [RSP_W-1:0] raw);
        case (raw)
            3'd0:    return RSP_NONE;
            3'd1:    return RSP_ACK;
            3'd2:    return RSP_MDATA;
            3'd3:    return RSP_DATA0;
            default: return RSP_OTHER;
        endcase
    endfunction

    function automatic logic no_later_cs(mask_t cm, uf_t uf);
        logic [UF_W:0] sh;
        mask_t hi;
        sh = {1'b0, uf} + 1'b1;
        hi = cm >> sh;
        return (hi == '0);
    endfunction
endpackage

// File: rtl/split_decide.sv
module split_decide
    import sst_pkg::*;
(
    input  ctx_t ctx_i,
    input  uf_t  uf_i,
    output act_e act_o
);
    always_comb begin
        act_o = ACT_NONE;
        if (ctx_i.active) begin
            if (ctx_i.st == ST_SS) begin
                if (ctx_i.smask[uf_i]) act_o = ACT_SS;
            end else begin
                if (ctx_i.cmask[uf_i]) act_o = ACT_CS;
            end
        end
    end
endmodule

// File: rtl/split_resp.sv
module split_resp
    import sst_pkg::*;
(
    input  ctx_t ctx_i,
    input  act_e act_i,
    input  rsp_e rsp_i,
    input  logic last_i,
    output ctx_t ctx_o
);
    always_comb begin
        ctx_o = ctx_i;
        if (act_i == ACT_SS) begin
            ctx_o.st = ST_CS;
        end else if (act_i == ACT_CS) begin
            case (rsp_i)
                RSP_MDATA: ctx_o = ctx_i;
                RSP_DATA0: begin
                    ctx_o.active = 1'b0;
                    ctx_o.st     = ST_SS;
                end
                default: begin
                    if (last_i) begin
                        ctx_o.active = 1'b0;
                        ctx_o.err    = 1'b1;
                        ctx_o.st     = ST_SS;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/iso_split_tracker.sv
module iso_split_tracker
    import sst_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        uf_tick,
    input  logic [2:0]  uf_idx,
    input  logic        desc_load,
    input  logic [7:0]  ld_smask,
    input  logic [7:0]  ld_cmask,
    input  logic        ld_carry,
    input  logic        ld_back_ok,
    output logic        tx_req,
    output logic [1:0]  tx_kind,
    output logic        tx_ctx,
    input  logic        tx_done,
    input  logic [2:0]  tx_resp,
    output logic        busy,
    output logic        frame_wrap,
    output logic        cur_state,
    output logic        cur_active,
    output logic        cur_err,
    output logic        prev_state,
    output logic        prev_active,
    output logic        prev_err
);
    ctx_t ctx_q [NCTX];
    act_e dec_act [NCTX];
    sq_e  sq_q;
    uf_t  uf_q;
    uf_t  last_uf_q;
    logic seen_q;
    logic back_ok_q;
    logic sel_q;
    act_e act_q;
    ctx_t ctx_sel;
    ctx_t ctx_upd;
    logic prev_go;

    for (genvar g = 0; g < NCTX; g++) begin : g_dec
        split_decide u_dec (
            .ctx_i (ctx_q[g]),
            .uf_i  (uf_q),
            .act_o (dec_act[g])
        );
    end

    assign ctx_sel = sel_q ? ctx_q[1] : ctx_q[0];

    split_resp u_rsp (
        .ctx_i  (ctx_sel),
        .act_i  (act_q),
        .rsp_i  (decode_rsp(tx_resp)),
        .last_i (no_later_cs(ctx_sel.cmask, uf_q)),
        .ctx_o  (ctx_upd)
    );

    assign prev_go = back_ok_q && !ctx_q[0].smask[0] && (dec_act[1] == ACT_CS);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCTX; i++) ctx_q[i] <= '0;
            sq_q       <= SQ_IDLE;
            uf_q       <= '0;
            last_uf_q  <= '0;
            seen_q     <= 1'b0;
            back_ok_q  <= 1'b0;
            sel_q      <= SEL_CUR;
            act_q      <= ACT_NONE;
            frame_wrap <= 1'b0;
        end else begin
            frame_wrap <= 1'b0;
            case (sq_q)
                SQ_IDLE: begin
                    if (desc_load) begin
                        ctx_q[1]  <= ctx_q[0];
                        ctx_q[0]  <= '{st: (ld_carry ? ST_CS : ST_SS), active: 1'b1,
                                       err: 1'b0, smask: ld_smask, cmask: ld_cmask};
                        back_ok_q <= ld_back_ok;
                    end else if (uf_tick) begin
                        frame_wrap <= seen_q && (last_uf_q == uf_t'(UF_N - 1)) && (uf_idx == '0);
                        uf_q       <= uf_idx;
                        last_uf_q  <= uf_idx;
                        seen_q     <= 1'b1;
                        sq_q       <= SQ_PREV;
                    end
                end
                SQ_PREV: begin
                    if (prev_go) begin
                        sel_q <= SEL_PREV;
                        act_q <= ACT_CS;
                        sq_q  <= SQ_WAIT;
                    end else begin
                        sq_q  <= SQ_CUR;
                    end
                end
                SQ_CUR: begin
                    if (dec_act[0] != ACT_NONE) begin
                        sel_q <= SEL_CUR;
                        act_q <= dec_act[0];
                        sq_q  <= SQ_WAIT;
                    end else begin
                        sq_q  <= SQ_IDLE;
                    end
                end
                SQ_WAIT: begin
                    if (tx_done) begin
                        if (sel_q) ctx_q[1] <= ctx_upd;
                        else       ctx_q[0] <= ctx_upd;
                        sq_q <= sel_q ? SQ_CUR : SQ_IDLE;
                    end
                end
                default: sq_q <= SQ_IDLE;
            endcase
        end
    end

    assign tx_req      = (sq_q == SQ_WAIT);
    assign tx_kind     = act_q;
    assign tx_ctx      = sel_q;
    assign busy        = (sq_q != SQ_IDLE);
    assign cur_state   = ctx_q[0].st;
    assign cur_active  = ctx_q[0].active;
    assign cur_err     = ctx_q[0].err;
    assign prev_state  = ctx_q[1].st;
    assign prev_active = ctx_q[1].active;
    assign prev_err    = ctx_q[1].err;

    // R3: a start-split only for the current context in an S-mask micro-frame
    a_r3_ss_in_smask: assert property (@(posedge clk) disable iff (rst)
        (tx_req && tx_kind == ACT_SS) |-> (!tx_ctx && ctx_q[0].smask[uf_q] && ctx_q[0].st == ST_SS));

    // R8: back-link service only under its gating conditions
    a_r8_prev_gate: assert property (@(posedge clk) disable iff (rst)
        (tx_req && tx_ctx) |-> (back_ok_q && !ctx_q[0].smask[0] && tx_kind == ACT_CS));

    // R10: request held stable until done
    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_req && !tx_done) |=> (tx_req && $stable(tx_kind) && $stable(tx_ctx)));

    // R5: MDATA keeps the current context pending
    a_r5_mdata_keeps: assert property (@(posedge clk) disable iff (rst)
        (tx_req && tx_done && !tx_ctx && tx_kind == ACT_CS && tx_resp == 3'd2)
        |=> (cur_active && cur_state == ST_CS));

    // R6: DATA0 retires the current context
    a_r6_data0_retire: assert property (@(posedge clk) disable iff (rst)
        (tx_req && tx_done && !tx_ctx && tx_kind == ACT_CS && tx_resp == 3'd3)
        |=> (!cur_active && cur_state == ST_SS));

    // R11: frame boundary pulse lasts one cycle
    a_r11_wrap_pulse: assert property (@(posedge clk) disable iff (rst)
        frame_wrap |=> !frame_wrap);

    // R9: previous context only changes on a load or its own completed transaction
    a_r9_prev_quiet: assert property (@(posedge clk) disable iff (rst)
        (sq_q != SQ_IDLE && !(tx_req && tx_ctx && tx_done)) |=> $stable(ctx_q[1]));
endmodule

// File: tb/sim_iso_split_tracker.sv
module sim_iso_split_tracker;
    logic       clk = 1'b0;
    logic       rst;
    logic       uf_tick = 1'b0;
    logic [2:0] uf_idx = '0;
    logic       desc_load = 1'b0;
    logic [7:0] ld_smask = '0;
    logic [7:0] ld_cmask = '0;
    logic       ld_carry = 1'b0;
    logic       ld_back_ok = 1'b0;
    logic       tx_req;
    logic [1:0] tx_kind;
    logic       tx_ctx;
    logic       tx_done = 1'b0;
    logic [2:0] tx_resp = '0;
    logic       busy, frame_wrap;
    logic       cur_state, cur_active, cur_err;
    logic       prev_state, prev_active, prev_err;

    int n_run = 0;
    int n_fail = 0;
    int fw_seen = 0;
    logic finished = 1'b0;

    typedef struct { int ctx; int kind; int resp; } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    iso_split_tracker u0 (
        .clk(clk), .rst(rst), .uf_tick(uf_tick), .uf_idx(uf_idx),
        .desc_load(desc_load), .ld_smask(ld_smask), .ld_cmask(ld_cmask),
        .ld_carry(ld_carry), .ld_back_ok(ld_back_ok),
        .tx_req(tx_req), .tx_kind(tx_kind), .tx_ctx(tx_ctx),
        .tx_done(tx_done), .tx_resp(tx_resp), .busy(busy), .frame_wrap(frame_wrap),
        .cur_state(cur_state), .cur_active(cur_active), .cur_err(cur_err),
        .prev_state(prev_state), .prev_active(prev_active), .prev_err(prev_err)
    );

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic expect_tx(int c, int k, int r);
        exp_t e;
        e.ctx = c; e.kind = k; e.resp = r;
        exp_q.push_back(e);
    endtask

    // monitor: pops expected transactions and answers them
    initial begin
        forever begin
            @(negedge clk);
            if (tx_done) begin
                tx_done = 1'b0;
            end else if (tx_req) begin
                logic [1:0] k0;
                logic       c0;
                exp_t e;
                k0 = tx_kind; c0 = tx_ctx;
                @(negedge clk);
                chk("R10 request held", int'(tx_req && tx_kind == k0 && tx_ctx == c0), 1);
                if (exp_q.size() == 0) begin
                    chk("R3/R4/R8 unexpected transaction", 1, 0);
                    tx_resp = 3'd0;
                end else begin
                    e = exp_q.pop_front();
                    chk("R8 transaction context", int'(tx_ctx), e.ctx);
                    chk("R3/R4 transaction kind", int'(tx_kind), e.kind);
                    tx_resp = 3'(e.resp);
                end
                tx_done = 1'b1;
            end
        end
    end

    task automatic load(logic [7:0] sm, logic [7:0] cm, logic cy, logic bk);
        @(negedge clk);
        desc_load = 1'b1; ld_smask = sm; ld_cmask = cm; ld_carry = cy; ld_back_ok = bk;
        @(negedge clk);
        desc_load = 1'b0;
    endtask

    task automatic tick(int u, string tag);
        @(negedge clk);
        uf_tick = 1'b1; uf_idx = 3'(u);
        @(negedge clk);
        uf_tick = 1'b0;
        fw_seen = int'(frame_wrap);
        while (busy) @(negedge clk);
        @(negedge clk);
        chk({tag, " all expected transactions made"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 cur_active", int'(cur_active), 0);
        chk("R1 cur_state", int'(cur_state), 0);
        chk("R1 prev_active", int'(prev_active), 0);
        chk("R1 cur_err", int'(cur_err), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 tx_req", int'(tx_req), 0);

        // Frame X: start-split at 4, complete-splits at 6,7; C-mask bit 0 ignored
        load(8'h10, 8'hC1, 1'b0, 1'b0);
        chk("R2 load state", int'(cur_state), 0);
        chk("R2 load active", int'(cur_active), 1);
        for (int u = 0; u < 4; u++) tick(u, "R3");
        chk("R3 cmask ignored in start state", int'(cur_state), 0);
        expect_tx(0, 1, 1); tick(4, "R3");
        chk("R3 state after start-split", int'(cur_state), 1);
        tick(5, "R4");
        expect_tx(0, 2, 2); tick(6, "R4");
        chk("R5 mdata active", int'(cur_active), 1);
        chk("R5 mdata state", int'(cur_state), 1);
        expect_tx(0, 2, 2); tick(7, "R5");
        chk("R5 mdata on last active", int'(cur_active), 1);

        // Frame X+1: back-link service of frame X descriptor
        load(8'h10, 8'hC0, 1'b0, 1'b1);
        chk("R2 prev slot state", int'(prev_state), 1);
        chk("R2 prev slot active", int'(prev_active), 1);
        chk("R2 new cur state", int'(cur_state), 0);
        expect_tx(1, 2, 3); tick(0, "R8");
        chk("R11 frame_wrap pulse", fw_seen, 1);
        chk("R8 prev retired active", int'(prev_active), 0);
        chk("R8 prev retired state", int'(prev_state), 0);
        chk("R8 cur untouched", int'(cur_active), 1);
        tick(1, "R9");
        chk("R9 prev active unchanged", int'(prev_active), 0);
        chk("R9 prev err unchanged", int'(prev_err), 0);
        tick(2, "R11");
        chk("R11 no pulse mid frame", fw_seen, 0);
        tick(3, "R3");
        expect_tx(0, 1, 1); tick(4, "R3");
        tick(5, "R4");
        expect_tx(0, 2, 3); tick(6, "R6");
        chk("R6 data0 active", int'(cur_active), 0);
        chk("R6 data0 state", int'(cur_state), 0);
        tick(7, "R6 remaining complete-split skipped");

        // Frame X+2: error exit on last complete-split
        load(8'h01, 8'h0E, 1'b0, 1'b1);
        expect_tx(0, 1, 1); tick(0, "R8");
        chk("R11 frame_wrap again", fw_seen, 1);
        expect_tx(0, 2, 0); tick(1, "R7");
        chk("R7 none not last active", int'(cur_active), 1);
        chk("R7 none not last err", int'(cur_err), 0);
        expect_tx(0, 2, 6); tick(2, "R7");
        chk("R7 other not last active", int'(cur_active), 1);
        expect_tx(0, 2, 0); tick(3, "R7");
        chk("R7 last active", int'(cur_active), 0);
        chk("R7 last err", int'(cur_err), 1);
        chk("R7 last state", int'(cur_state), 0);
        for (int u = 4; u < 8; u++) tick(u, "R7");

        // Frame X+3: carried-over descriptor starts in complete-split state
        load(8'h00, 8'h03, 1'b1, 1'b0);
        chk("R2 carry state", int'(cur_state), 1);
        expect_tx(0, 2, 2); tick(0, "R4");
        expect_tx(0, 2, 2); tick(1, "R4");
        chk("R4 carry active", int'(cur_active), 1);
        chk("R4 carry state", int'(cur_state), 1);
        for (int u = 2; u < 8; u++) tick(u, "R4");

        // Frame X+4: S-mask bit 0 set blocks the back-link service
        load(8'h01, 8'h01, 1'b0, 1'b1);
        expect_tx(0, 1, 1); tick(0, "R8");
        tick(1, "R8");
        chk("R8 smask0 blocks prev active", int'(prev_active), 1);
        chk("R8 smask0 blocks prev state", int'(prev_state), 1);
        for (int u = 2; u < 8; u++) tick(u, "R8");

        // Frame X+5: invalid back-link blocks the service
        load(8'h02, 8'h00, 1'b0, 1'b0);
        tick(0, "R8");
        chk("R8 no back-link prev active", int'(prev_active), 1);
        chk("R8 no back-link prev state", int'(prev_state), 1);
        expect_tx(0, 1, 1); tick(1, "R3");
        chk("R3 state after late start-split", int'(cur_state), 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule